// File: doc/BRIEF.md
# Nanosecond Real-Time Counter with Alarm

This peripheral keeps a 64-bit nanosecond count that advances by a fixed step on every clock cycle. Software reads and sets the count through a single-cycle 32-bit register port, one half-word at a time. A 64-bit compare value can be armed as an alarm. When the count reaches it, a pending flag is set. That flag drives a level interrupt line, which only passes when the enable bit is on.

Reading the low count word also latches the live upper word into a holding register. A later read of the high word then returns a value that matches the low word already read, even if a carry happened between the two accesses. The alarm is armed only when its low word is written. If the value written is already at or behind the count, the alarm fires in that same cycle instead of arming.

Top module: `ns_rtc`

## Requirements
- R1: After reset, the alarm halves, the enable register, the alarm status and the held high word all read 0, and the interrupt output is low.
- R2: The count grows by STEP_NS (default 10) on each clock edge. A read at offset 0x00 returns the count's bits 31:0 as they stand in that cycle.
- R3: A read at 0x00 copies bits 63:32 of the count into a holding register. A read at 0x04 returns that held value, not the live upper word, and a write at 0x04 leaves the held value unchanged.
- R4: A write at 0x00 replaces bits 31:0 of the count. A write at 0x04 replaces bits 63:32. The other half keeps advancing, including the carry out of the low word.
- R5: A write at 0x0C only stores bits 63:32 of the alarm value. It neither arms the alarm nor raises the pending flag.
- R6: A write at 0x08 stores bits 31:0 of the alarm value and then arms the alarm. If the full value is greater than the count after this edge, alarm status (bit 0 at 0x18) reads 1.
- R7: If, at arming, the alarm value is less than or equal to the count after this edge, the alarm is not left running and the pending flag sets in that same edge.
- R8: A running alarm expires on the first edge where the updated count is greater than or equal to the alarm value. On that edge the running flag clears and the pending flag sets.
- R9: The interrupt output equals pending AND enable. A write at 0x10 keeps only bit 0 as the enable, and 0x10 reads it back in bit 0.
- R10: Any write at 0x14 stops a running alarm and leaves the pending flag as it was.
- R11: Any write at 0x1C clears the pending flag. An expiry in the same edge takes precedence.
- R12: Reads at 0x14, 0x1C, 0x20 and at offsets that are not word-aligned return 0. Writes at 0x18, 0x20 and 0x24 change no state.
- R13: When a count write and an alarm compare fall in the same edge, the compare uses the newly written count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata_i | input | WORD_W (32) | Write data |
| bus_rdata_o | output | WORD_W (32) | Read data, valid in the same cycle as the read access |
| irq_o | output | 1 | Level interrupt, pending AND enable |

## Verification
The count step shows up directly: one wrong increment makes every later low-word read wrong by a multiple of the step. A faulty holding register shows only on the next high-word read. An arming or expiry fault that is wrong by one edge shows on the interrupt line one cycle after the edge where the pending flag should have changed. The bench therefore checks the interrupt in every cycle against its own reference model. It also places status reads directly after each arm, clear and count-jump write, so a wrong running flag is visible in the very next cycle.

// File: rtl/ns_rtc_pkg.sv
package ns_rtc_pkg;

  localparam int unsigned OFS_TLO  = 'h00;
  localparam int unsigned OFS_THI  = 'h04;
  localparam int unsigned OFS_ALO  = 'h08;
  localparam int unsigned OFS_AHI  = 'h0C;
  localparam int unsigned OFS_IEN  = 'h10;
  localparam int unsigned OFS_CALM = 'h14;
  localparam int unsigned OFS_STAT = 'h18;
  localparam int unsigned OFS_CINT = 'h1C;

  typedef struct packed {
    logic wr_tlo;
    logic wr_thi;
    logic wr_alo;
    logic wr_ahi;
    logic wr_ien;
    logic wr_calm;
    logic wr_cint;
    logic rd_tlo;
  } rtc_strb_t;

  typedef enum logic [2:0] {
    RS_ZERO, RS_TLO, RS_THI, RS_ALO, RS_AHI, RS_IEN, RS_STAT
  } rtc_rsel_e;

endpackage

// File: rtl/ns_rtc_decode.sv
module ns_rtc_decode
  import ns_rtc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output rtc_strb_t         strb_o,
  output rtc_rsel_e         rsel_o
);

  localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'(OFS_TLO);
  localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'(OFS_THI);
  localparam logic [ADDR_W-1:0] A_ALO  = ADDR_W'(OFS_ALO);
  localparam logic [ADDR_W-1:0] A_AHI  = ADDR_W'(OFS_AHI);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_CALM = ADDR_W'(OFS_CALM);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CINT = ADDR_W'(OFS_CINT);

  always_comb begin
    strb_o = '0;
    rsel_o = RS_ZERO;
    if (sel_i && wr_i) begin
      case (addr_i)
        A_TLO:   strb_o.wr_tlo  = 1'b1;
        A_THI:   strb_o.wr_thi  = 1'b1;
        A_ALO:   strb_o.wr_alo  = 1'b1;
        A_AHI:   strb_o.wr_ahi  = 1'b1;
        A_IEN:   strb_o.wr_ien  = 1'b1;
        A_CALM:  strb_o.wr_calm = 1'b1;
        A_CINT:  strb_o.wr_cint = 1'b1;
        default: ;
      endcase
    end else if (sel_i) begin
      case (addr_i)
        A_TLO: begin
          rsel_o        = RS_TLO;
          strb_o.rd_tlo = 1'b1;
        end
        A_THI:   rsel_o = RS_THI;
        A_ALO:   rsel_o = RS_ALO;
        A_AHI:   rsel_o = RS_AHI;
        A_IEN:   rsel_o = RS_IEN;
        A_STAT:  rsel_o = RS_STAT;
        default: rsel_o = RS_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/ns_rtc_count.sv
module ns_rtc_count #(
  parameter int WORD_W  = 32,
  parameter int STEP_NS = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic                  rd_lo_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [2*WORD_W-1:0]   cnt_q_o,
  output logic [2*WORD_W-1:0]   cnt_nx_o,
  output logic [WORD_W-1:0]     hold_q_o
);

  localparam int CNT_W = 2 * WORD_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP_NS);

  logic [CNT_W-1:0]  cnt_q, cnt_nx, cnt_inc;
  logic [WORD_W-1:0] hold_q, hold_nx;

  always_comb begin
    cnt_inc = cnt_q + STEP_V;
    cnt_nx  = cnt_inc;
    if (wr_lo_i)      cnt_nx = {cnt_inc[CNT_W-1:WORD_W], wdata_i};
    else if (wr_hi_i) cnt_nx = {wdata_i, cnt_inc[WORD_W-1:0]};
    hold_nx = rd_lo_i ? cnt_q[CNT_W-1:WORD_W] : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (rd_lo_i) hold_q <= hold_nx;
    end
  end

  assign cnt_q_o  = cnt_q;
  assign cnt_nx_o = cnt_nx;
  assign hold_q_o = hold_q;

endmodule

// File: rtl/ns_rtc_alarm.sv
module ns_rtc_alarm #(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic                stop_i,
  input  logic                ack_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [2*WORD_W-1:0] cnt_nx_i,
  output logic [2*WORD_W-1:0] alarm_q_o,
  output logic                run_q_o,
  output logic                pend_q_o,
  output logic                expire_o
);

  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] alarm_q, alarm_nx;
  logic             run_q, run_nx, pend_q, pend_nx, reached, expire;

  always_comb begin
    alarm_nx = alarm_q;
    if (wr_hi_i) alarm_nx[CNT_W-1:WORD_W] = wdata_i;
    if (wr_lo_i) alarm_nx[WORD_W-1:0]     = wdata_i;
    reached = (alarm_nx <= cnt_nx_i);

    run_nx = run_q;
    expire = 1'b0;
    if (wr_lo_i) begin
      run_nx = !reached;
      expire = reached;
    end else if (stop_i) begin
      run_nx = 1'b0;
    end else if (run_q && reached) begin
      run_nx = 1'b0;
      expire = 1'b1;
    end

    pend_nx = pend_q;
    if (ack_i)  pend_nx = 1'b0;
    if (expire) pend_nx = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_lo_i || wr_hi_i) alarm_q <= alarm_nx;
      run_q  <= run_nx;
      pend_q <= pend_nx;
    end
  end

  assign alarm_q_o = alarm_q;
  assign run_q_o   = run_q;
  assign pend_q_o  = pend_q;
  assign expire_o  = expire;

endmodule

// File: rtl/ns_rtc.sv
module ns_rtc
  import ns_rtc_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 32,
  parameter int STEP_NS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int CNT_W = 2 * WORD_W;

  logic rst_meta, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  rtc_strb_t        strb;
  rtc_rsel_e        rsel;
  logic [CNT_W-1:0] cnt_q, cnt_nx, alarm_q;
  logic [WORD_W-1:0] hold_q;
  logic             run_q, pend_q, expire;
  logic             en_q, en_nx;

  ns_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel_i),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .strb_o (strb),
    .rsel_o (rsel)
  );

  ns_rtc_count #(.WORD_W(WORD_W), .STEP_NS(STEP_NS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_q),
    .wr_lo_i  (strb.wr_tlo),
    .wr_hi_i  (strb.wr_thi),
    .rd_lo_i  (strb.rd_tlo),
    .wdata_i  (bus_wdata_i),
    .cnt_q_o  (cnt_q),
    .cnt_nx_o (cnt_nx),
    .hold_q_o (hold_q)
  );

  ns_rtc_alarm #(.WORD_W(WORD_W)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_q),
    .wr_lo_i   (strb.wr_alo),
    .wr_hi_i   (strb.wr_ahi),
    .stop_i    (strb.wr_calm),
    .ack_i     (strb.wr_cint),
    .wdata_i   (bus_wdata_i),
    .cnt_nx_i  (cnt_nx),
    .alarm_q_o (alarm_q),
    .run_q_o   (run_q),
    .pend_q_o  (pend_q),
    .expire_o  (expire)
  );

  always_comb en_nx = bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q)           en_q <= 1'b0;
    else if (strb.wr_ien) en_q <= en_nx;
  end

  assign irq_o = pend_q & en_q;

  always_comb begin
    case (rsel)
      RS_TLO:  bus_rdata_o = cnt_q[WORD_W-1:0];
      RS_THI:  bus_rdata_o = hold_q;
      RS_ALO:  bus_rdata_o = alarm_q[WORD_W-1:0];
      RS_AHI:  bus_rdata_o = alarm_q[CNT_W-1:WORD_W];
      RS_IEN:  bus_rdata_o = WORD_W'(en_q);
      RS_STAT: bus_rdata_o = WORD_W'(run_q);
      default: bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/ns_rtc_chk.sv
module ns_rtc_chk
  import ns_rtc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int STEP_NS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input rtc_strb_t           strb,
  input logic                expire,
  input logic [2*WORD_W-1:0] cnt_q,
  input logic [WORD_W-1:0]   hold_q,
  input logic                run_q,
  input logic                pend_q,
  input logic                en_q,
  input logic                irq,
  input logic                wbit0
);

  localparam int CNT_W = 2 * WORD_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP_NS);

  // R2: count moves by one step when no half is written
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wr_tlo && !strb.wr_thi) |=> cnt_q == $past(cnt_q) + STEP_V);

  // R3: held word changes only on a low-word read, and then takes the upper count
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rd_tlo |=> $stable(hold_q));
  p_hold_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd_tlo |=> hold_q == $past(cnt_q[CNT_W-1:WORD_W]));

  // R5: upper alarm write never starts the alarm
  p_high_no_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wr_ahi && !run_q) |=> !run_q);

  // R8: an expiry leaves the alarm stopped and the interrupt pending
  p_expire_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pend_q && !run_q));

  // R9: enable keeps bit 0; output never high without pending and enable
  p_enable_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wr_ien |=> en_q == $past(wbit0));
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q || !en_q) |-> !irq);

  // R10: stopping the alarm clears running and keeps pending
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wr_calm |=> (!run_q && pend_q == $past(pend_q)));

  // R11: acknowledge clears pending unless an expiry lands together
  p_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wr_cint && !expire) |=> !pend_q);

endmodule

bind ns_rtc ns_rtc_chk #(.WORD_W(WORD_W), .STEP_NS(STEP_NS)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_q),
  .strb   (strb),
  .expire (expire),
  .cnt_q  (cnt_q),
  .hold_q (hold_q),
  .run_q  (run_q),
  .pend_q (pend_q),
  .en_q   (en_q),
  .irq    (irq_o),
  .wbit0  (bus_wdata_i[0])
);

// File: tb/ns_rtc_test.sv
module ns_rtc_test;

  localparam int STEP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #5 clk = ~clk;

  ns_rtc uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          crd;
    logic [31:0] exp_rd;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [63:0] m_cnt = '0, m_alarm = '0;
  logic [31:0] m_hold = '0;
  logic        m_run = 0, m_pend = 0, m_en = 0, m_cv = 0, m_hiw = 0;

  task automatic cyc(input logic s, input logic w, input logic [5:0] a,
                     input logic [31:0] d, input bit crd, input string tag);
    item_t it;
    logic [63:0] inc, ncnt, nal;
    logic        nrun, npend, hit, fire;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d;
    it.crd = crd && s && !w;
    it.tag = tag;
    case (a)
      6'h00: begin it.exp_rd = m_cnt[31:0]; if (!m_cv) it.crd = 0; end
      6'h04: it.exp_rd = m_hold;
      6'h08: it.exp_rd = m_alarm[31:0];
      6'h0C: it.exp_rd = m_alarm[63:32];
      6'h10: it.exp_rd = {31'b0, m_en};
      6'h18: it.exp_rd = {31'b0, m_run};
      default: it.exp_rd = '0;
    endcase
    it.exp_irq = m_pend & m_en;
    q.push_back(it);
    @(posedge clk);
    inc = m_cnt + 64'(STEP);
    ncnt = inc;
    if (s && w && a == 6'h00) begin
      ncnt = {inc[63:32], d};
      if (m_hiw) m_cv = 1;
    end else if (s && w && a == 6'h04) begin
      ncnt = {d, inc[31:0]};
      m_hiw = 1;
    end
    if (s && !w && a == 6'h00) m_hold = m_cnt[63:32];
    nal = m_alarm;
    if (s && w && a == 6'h0C) nal[63:32] = d;
    if (s && w && a == 6'h08) nal[31:0] = d;
    hit = (nal <= ncnt);
    fire = 0; nrun = m_run;
    if (s && w && a == 6'h08) begin nrun = !hit; fire = hit; end
    else if (s && w && a == 6'h14) nrun = 0;
    else if (m_run && hit) begin nrun = 0; fire = 1; end
    npend = m_pend;
    if (s && w && a == 6'h1C) npend = 0;
    if (fire) npend = 1;
    if (s && w && a == 6'h10) m_en = d[0];
    m_cnt = ncnt; m_alarm = nal; m_run = nrun; m_pend = npend;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, tag);
  endtask
  task automatic rd_reg(input logic [5:0] a, input string tag);
    cyc(1, 0, a, '0, 1, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, '0, '0, 0, tag);
  endtask

  // monitor: compares results shortly before the next rising edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.crd) begin
          checks++;
          if (rdata !== it.exp_rd) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", it.tag, rdata, it.exp_rd);
          end
        end
        checks++;
        if (irq !== it.exp_irq) begin
          errors++;
          $display("FAIL %s irq actual %b expected %b", it.tag, irq, it.exp_irq);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle("R1");
    // R1 reset state
    rd_reg(6'h04, "R1"); rd_reg(6'h08, "R1"); rd_reg(6'h0C, "R1");
    rd_reg(6'h10, "R1"); rd_reg(6'h18, "R1"); idle("R1");
    // R4 set both halves, R2 stepping
    wr_reg(6'h04, 32'h0000_0001, "R4");
    wr_reg(6'h00, 32'h1000_0000, "R4");
    rd_reg(6'h00, "R2");
    repeat (3) idle("R2");
    rd_reg(6'h00, "R2");
    rd_reg(6'h00, "R2");
    // R3 coherent high read
    rd_reg(6'h00, "R3");
    wr_reg(6'h04, 32'h0000_0055, "R3");
    rd_reg(6'h04, "R3");
    rd_reg(6'h00, "R3");
    rd_reg(6'h04, "R3");
    // R4 carry from low into high
    wr_reg(6'h00, 32'hFFFF_FFE0, "R4");
    rd_reg(6'h00, "R4");
    repeat (4) idle("R4");
    rd_reg(6'h00, "R4");
    rd_reg(6'h04, "R4");
    // R9 enable, R5 high alarm write does not arm
    wr_reg(6'h10, 32'h0000_0001, "R9");
    rd_reg(6'h10, "R9");
    wr_reg(6'h0C, 32'h0000_0000, "R5");
    rd_reg(6'h18, "R5");
    rd_reg(6'h0C, "R5");
    idle("R5");
    // R7 alarm in the past fires at once
    wr_reg(6'h08, 32'h0000_0005, "R7");
    rd_reg(6'h18, "R7");
    idle("R7");
    // R11 clear pending
    wr_reg(6'h1C, 32'h0, "R11");
    idle("R11");
    // R6 arm in future, R8 expiry
    wr_reg(6'h0C, m_cnt[63:32], "R6");
    wr_reg(6'h08, m_cnt[31:0] + 32'd200, "R6");
    rd_reg(6'h18, "R6");
    rd_reg(6'h08, "R6");
    repeat (25) idle("R8");
    rd_reg(6'h18, "R8");
    // R9 enable keeps bit 0 only
    wr_reg(6'h10, 32'hFFFF_FFFE, "R9");
    rd_reg(6'h10, "R9");
    idle("R9");
    wr_reg(6'h10, 32'h0000_0003, "R9");
    idle("R9");
    wr_reg(6'h1C, 32'h0, "R11");
    idle("R11");
    // R10 stop keeps pending
    wr_reg(6'h0C, 32'h0, "R10");
    wr_reg(6'h08, 32'h0, "R10");
    wr_reg(6'h0C, m_cnt[63:32] + 32'd1, "R10");
    wr_reg(6'h08, 32'h0, "R10");
    rd_reg(6'h18, "R10");
    wr_reg(6'h14, 32'h0, "R10");
    rd_reg(6'h18, "R10");
    idle("R10");
    wr_reg(6'h1C, 32'h0, "R11");
    idle("R11");
    // R12 ignored writes and zero reads
    wr_reg(6'h08, 32'h0, "R12");
    rd_reg(6'h18, "R12");
    wr_reg(6'h18, 32'h0, "R12");
    wr_reg(6'h20, 32'hFFFF_FFFF, "R12");
    wr_reg(6'h24, 32'hFFFF_FFFF, "R12");
    rd_reg(6'h18, "R12");
    rd_reg(6'h10, "R12");
    rd_reg(6'h14, "R12"); rd_reg(6'h1C, "R12");
    rd_reg(6'h20, "R12"); rd_reg(6'h02, "R12");
    idle("R12");
    wr_reg(6'h14, 32'h0, "R10");
    // R13 count jump past a running alarm
    wr_reg(6'h0C, m_cnt[63:32] + 32'd1, "R13");
    wr_reg(6'h08, 32'h0, "R13");
    rd_reg(6'h18, "R13");
    wr_reg(6'h04, m_cnt[63:32] + 32'd5, "R13");
    rd_reg(6'h18, "R13");
    idle("R13");
    wr_reg(6'h1C, 32'h0, "R11");
    repeat (3) idle("R11");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule